// File: doc/BRIEF.md
# Instruction Step Sequencer

This block is the hardwired timing core of a small accumulator machine's control unit. A 4-bit step counter advances once per clock and a decoder expands it into sixteen one-hot step lines. Whatever the execute logic needs, it builds from these lines together with the decoded operation lines. The first three steps of every instruction are fixed. Step 0 moves the program counter to the address register. Step 1 reads the instruction word and advances the program counter. Step 2 decodes the operation field, keeps the indirect bit and moves the address field of the instruction into the address register. The sequencer drives the bus source code and the register strobes for these three steps.

At step 3 the block sorts the held instruction into one of three types: memory-reference, register-reference or input/output. The execute units use this to pick up the instruction, and they end it by raising the clear request, which sends the counter back to step 0 on the next edge. A halt input freezes the sequence in place. The block sees only the top nibble of the instruction register: the indirect bit and the three opcode bits.

All pins are plain control or status levels. No data stream passes through this block, so there is no valid/ready handshake and no back-pressure.

Top module: `phase_sequencer`

## Requirements
- R1: A synchronous reset puts the counter at 0 and clears the operation lines and the indirect flag. While reset is high, `pc_clr` is 1, every strobe is 0 and `bus_sel` is 0. In the first cycle after reset, step line 0 is active.
- R2: With no reset, halt or clear, the counter advances by one on each clock. Exactly one bit of `step_line` is high, and its index is the counter value.
- R3: From step 15, with no clear and no halt, the counter goes to step 0.
- R4: A clear request with halt low sends the next cycle to step 0 from any step.
- R5: While halt is high, the counter holds its value, even if a clear request is present. All strobes are 0 and `bus_sel` is 0. The operation lines and the indirect flag are not updated.
- R6: At step 0, with no halt, `bus_sel` is 2 (program counter) and `ar_ld` is 1. `mem_rd`, `ir_ld` and `pc_inr` are 0.
- R7: At step 1, with no halt, `bus_sel` is 7 (memory), and `mem_rd`, `ir_ld` and `pc_inr` are 1. `ar_ld` is 0.
- R8: At step 2, with no halt, `bus_sel` is 5 (instruction register) and `ar_ld` is 1. The other strobes are 0. At the closing edge of step 2, `op_line` becomes one-hot with bit k set, where k is `ir_hi[2:0]` (instruction bits 14..12), and `ind_flag` takes `ir_hi[3]` (instruction bit 15).
- R9: Between loads at step 2, `op_line` and `ind_flag` hold their values whatever `ir_hi` does.
- R10: At step 3, exactly one type flag is 1. It is `is_regref` when op line 7 is set and the indirect flag is 0, `is_io` when op line 7 is set and the indirect flag is 1, and `is_memref` when op line 7 is clear. At any other step all three flags are 0.
- R11: At steps 3 to 15, `bus_sel` is 0 and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the sequence and suppresses strobes |
| sc_clear | input | 1 | End-of-instruction request; next step is 0 |
| ir_hi | input | 4 | Instruction bits 15..12 (indirect bit, opcode) |
| step_line | output | 16 | One-hot step lines T0..T15 |
| op_line | output | 8 | Held one-hot operation lines D0..D7 |
| ind_flag | output | 1 | Held indirect bit |
| bus_sel | output | 3 | Bus source code during fetch and decode |
| mem_rd | output | 1 | Memory read strobe |
| ar_ld | output | 1 | Address register load strobe |
| ir_ld | output | 1 | Instruction register load strobe |
| pc_inr | output | 1 | Program counter increment strobe |
| pc_clr | output | 1 | Program counter clear, follows reset |
| is_regref | output | 1 | Step 3: register-reference instruction |
| is_io | output | 1 | Step 3: input/output instruction |
| is_memref | output | 1 | Step 3: memory-reference instruction |

## Verification
The assertions take for granted that every input is synchronous to the rising edge and free of unknowns once reset has been seen at one edge. They also require `ir_hi` to be settled by the edge that closes step 2. The bench changes all inputs only at falling edges, holds reset through at least two rising edges before its first check, and drives a defined instruction nibble in every cycle. Halt and clear are raised at steps chosen to cover fetch, decode and the idle steps, including both at once.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int STEP_W = 4;
  localparam int OPC_W  = 3;

  // Fixed step indices of the fetch/decode prelude
  localparam int STEP_ADDR   = 0;
  localparam int STEP_FETCH  = 1;
  localparam int STEP_DECODE = 2;
  localparam int STEP_SORT   = 3;

  // Bus source codes; values are decoded by the bus multiplexer
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_t;

  typedef struct packed {
    logic mem_rd;
    logic ar_ld;
    logic ir_ld;
    logic pc_inr;
  } strobe_t;

endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int IN_W = 3
) (
  input  logic [IN_W-1:0]       sel,
  output logic [(1<<IN_W)-1:0]  hot
);
  localparam int N = 1 << IN_W;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot[i] = (sel == IN_W'(i));
  end
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (halt) cnt <= cnt;
    else if (clr)  cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (cnt == '0));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && !clr) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && !clr && cnt == LAST) |=> (cnt == '0));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !halt) |=> (cnt == '0));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(cnt));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import seq_pkg::*;
#(
  parameter int OPC_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    halt,
  input  logic [3:0]              t_early,
  input  logic [OPC_W:0]          ir_hi,
  output logic [(1<<OPC_W)-1:0]   op_line,
  output logic                    ind_flag,
  output bus_src_t                bus_sel,
  output strobe_t                 stb,
  output logic                    is_regref,
  output logic                    is_io,
  output logic                    is_memref
);
  localparam int OPS = 1 << OPC_W;
  localparam int TOP = OPS - 1;

  logic [OPS-1:0] op_hot;
  logic           act;

  onehot_dec #(.IN_W(OPC_W)) u_opdec (
    .sel (ir_hi[OPC_W-1:0]),
    .hot (op_hot)
  );

  assign act = !rst && !halt;

  always_comb begin
    bus_sel = SRC_NONE;
    stb     = '0;
    if (act) begin
      if (t_early[STEP_ADDR]) begin
        bus_sel   = SRC_PC;
        stb.ar_ld = 1'b1;
      end
      if (t_early[STEP_FETCH]) begin
        bus_sel    = SRC_MEM;
        stb.mem_rd = 1'b1;
        stb.ir_ld  = 1'b1;
        stb.pc_inr = 1'b1;
      end
      if (t_early[STEP_DECODE]) begin
        bus_sel   = SRC_IR;
        stb.ar_ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_line  <= '0;
      ind_flag <= 1'b0;
    end else if (act && t_early[STEP_DECODE]) begin
      op_line  <= op_hot;
      ind_flag <= ir_hi[OPC_W];
    end
  end

  assign is_regref = t_early[STEP_SORT] &&  op_line[TOP] && !ind_flag;
  assign is_io     = t_early[STEP_SORT] &&  op_line[TOP] &&  ind_flag;
  assign is_memref = t_early[STEP_SORT] && !op_line[TOP];

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (t_early[STEP_ADDR] && !halt) |-> (bus_sel == SRC_PC && stb == strobe_t'(4'b0100)));

  // R7
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (t_early[STEP_FETCH] && !halt) |-> (bus_sel == SRC_MEM && stb == strobe_t'(4'b1011)));

  // R8
  decode_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (t_early[STEP_DECODE] && !halt) |-> (bus_sel == SRC_IR && stb == strobe_t'(4'b0100)));

  // R8
  decode_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (t_early[STEP_DECODE] && !halt) |=>
      (op_line[$past(ir_hi[OPC_W-1:0])] && $countones(op_line) == 1
       && ind_flag == $past(ir_hi[OPC_W])));

  // R9
  hold_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !(t_early[STEP_DECODE] && !halt) |=> ($stable(op_line) && $stable(ind_flag)));

  // R5
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (stb == '0 && bus_sel == SRC_NONE));

  // R10
  sort_one_chk: assert property (@(posedge clk) disable iff (rst)
    t_early[STEP_SORT] |-> ($countones({is_regref, is_io, is_memref}) == 1));

  // R10
  sort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !t_early[STEP_SORT] |-> ({is_regref, is_io, is_memref} == 3'b000));

  // R11
  late_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(t_early[STEP_ADDR] || t_early[STEP_FETCH] || t_early[STEP_DECODE])
      |-> (stb == '0 && bus_sel == SRC_NONE));
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import seq_pkg::*;
#(
  parameter int STEP_W = seq_pkg::STEP_W,
  parameter int OPC_W  = seq_pkg::OPC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   halt,
  input  logic                   sc_clear,
  input  logic [OPC_W:0]         ir_hi,
  output logic [(1<<STEP_W)-1:0] step_line,
  output logic [(1<<OPC_W)-1:0]  op_line,
  output logic                   ind_flag,
  output logic [2:0]             bus_sel,
  output logic                   mem_rd,
  output logic                   ar_ld,
  output logic                   ir_ld,
  output logic                   pc_inr,
  output logic                   pc_clr,
  output logic                   is_regref,
  output logic                   is_io,
  output logic                   is_memref
);
  localparam int STEPS = 1 << STEP_W;

  logic [STEP_W-1:0] cnt;
  bus_src_t          bus_q;
  strobe_t           stb;

  step_counter #(.W(STEP_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .halt (halt),
    .clr  (sc_clear),
    .cnt  (cnt)
  );

  onehot_dec #(.IN_W(STEP_W)) u_stepdec (
    .sel (cnt),
    .hot (step_line)
  );

  fetch_ctrl #(.OPC_W(OPC_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .t_early   (step_line[3:0]),
    .ir_hi     (ir_hi),
    .op_line   (op_line),
    .ind_flag  (ind_flag),
    .bus_sel   (bus_q),
    .stb       (stb),
    .is_regref (is_regref),
    .is_io     (is_io),
    .is_memref (is_memref)
  );

  assign bus_sel = bus_q;
  assign mem_rd  = stb.mem_rd;
  assign ar_ld   = stb.ar_ld;
  assign ir_ld   = stb.ir_ld;
  assign pc_inr  = stb.pc_inr;
  assign pc_clr  = rst;

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(step_line) == 1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (pc_clr && !mem_rd && !ar_ld && !ir_ld && !pc_inr && bus_sel == 3'd0));

  // R1
  reset_lines_chk: assert property (@(posedge clk)
    rst |=> (step_line[0] && op_line == '0 && !ind_flag));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (step_line == $past(step_line) && op_line == $past(op_line)));

  initial begin
    if (STEPS < 4) $error("phase_sequencer needs at least four steps");
  end
endmodule

// File: tb/sim_phase_sequencer.sv
module sim_phase_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic        sc_clear = 1'b0;
  logic [3:0]  ir_hi = 4'h0;
  logic [15:0] step_line;
  logic [7:0]  op_line;
  logic        ind_flag;
  logic [2:0]  bus_sel;
  logic        mem_rd, ar_ld, ir_ld, pc_inr, pc_clr;
  logic        is_regref, is_io, is_memref;

  always #5 clk = ~clk;

  phase_sequencer u0 (
    .clk (clk), .rst (rst), .halt (halt), .sc_clear (sc_clear), .ir_hi (ir_hi),
    .step_line (step_line), .op_line (op_line), .ind_flag (ind_flag),
    .bus_sel (bus_sel), .mem_rd (mem_rd), .ar_ld (ar_ld), .ir_ld (ir_ld),
    .pc_inr (pc_inr), .pc_clr (pc_clr), .is_regref (is_regref),
    .is_io (is_io), .is_memref (is_memref)
  );

  typedef struct {
    logic [15:0] tm;
    logic [7:0]  op;
    logic        ind;
    logic [2:0]  bus;
    logic [3:0]  stb;   // {mem_rd, ar_ld, ir_ld, pc_inr}
    logic        pcclr;
    logic [2:0]  cls;   // {regref, io, memref}
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Reference state from the requirements
  logic [3:0] m_cnt = 4'd0;
  logic [7:0] m_op  = 8'd0;
  logic       m_ind = 1'b0;

  task automatic step(input logic r, input logic h, input logic c,
                      input logic [3:0] ir, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; halt = h; sc_clear = c; ir_hi = ir;
    e.tm    = 16'd1 << m_cnt;
    e.op    = m_op;
    e.ind   = m_ind;
    e.pcclr = r;
    e.bus   = 3'd0;
    e.stb   = 4'b0000;
    if (!r && !h) begin
      case (m_cnt)
        4'd0: begin e.bus = 3'd2; e.stb = 4'b0100; end
        4'd1: begin e.bus = 3'd7; e.stb = 4'b1011; end
        4'd2: begin e.bus = 3'd5; e.stb = 4'b0100; end
        default: ;
      endcase
    end
    e.cls = (m_cnt == 4'd3) ? {m_op[7] && !m_ind, m_op[7] && m_ind, !m_op[7]} : 3'b000;
    e.tag = tag;
    q.push_back(e);
    if (r) begin
      m_cnt = 4'd0; m_op = 8'd0; m_ind = 1'b0;
    end else if (!h) begin
      if (m_cnt == 4'd2) begin
        m_op  = 8'd1 << ir[2:0];
        m_ind = ir[3];
      end
      m_cnt = c ? 4'd0 : m_cnt + 4'd1;
    end
  endtask

  task automatic run_instr(input logic [3:0] ir, input int last);
    string t;
    for (int k = 0; k <= last; k++) begin
      case (k)
        0: t = "R6";
        1: t = "R7";
        2: t = "R8";
        3: t = "R10";
        default: t = "R11";
      endcase
      if (k == last) t = {t, "/R4"};
      step(1'b0, 1'b0, k == last, ir, t);
    end
  endtask

  // Monitor: compare each cycle against the queued expectation
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (step_line !== e.tm || op_line !== e.op || ind_flag !== e.ind ||
          bus_sel !== e.bus || {mem_rd, ar_ld, ir_ld, pc_inr} !== e.stb ||
          pc_clr !== e.pcclr || {is_regref, is_io, is_memref} !== e.cls) begin
        n_bad++;
        $display("FAIL %s: actual step=%h op=%h ind=%b bus=%0d stb=%b pcclr=%b cls=%b | expected step=%h op=%h ind=%b bus=%0d stb=%b pcclr=%b cls=%b",
                 e.tag, step_line, op_line, ind_flag, bus_sel,
                 {mem_rd, ar_ld, ir_ld, pc_inr}, pc_clr, {is_regref, is_io, is_memref},
                 e.tm, e.op, e.ind, e.bus, e.stb, e.pcclr, e.cls);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R1: reset state
    step(1'b1, 1'b0, 1'b0, 4'h0, "R1");
    step(1'b1, 1'b0, 1'b1, 4'hF, "R1");

    run_instr(4'h8, 4);   // indirect memory-reference
    run_instr(4'h7, 3);   // register-reference
    run_instr(4'hF, 3);   // input/output
    run_instr(4'h1, 5);   // direct memory-reference

    // R5: halt at step 1 with a clear request present
    step(1'b0, 1'b0, 1'b0, 4'h2, "R6");
    step(1'b0, 1'b1, 1'b1, 4'h2, "R5");
    step(1'b0, 1'b1, 1'b1, 4'h2, "R5");
    step(1'b0, 1'b1, 1'b0, 4'h2, "R5");
    step(1'b0, 1'b0, 1'b0, 4'h2, "R7");
    step(1'b0, 1'b0, 1'b0, 4'h5, "R8");
    step(1'b0, 1'b0, 1'b1, 4'h5, "R10/R4");

    // R9: instruction nibble changes after decode
    step(1'b0, 1'b0, 1'b0, 4'h7, "R6");
    step(1'b0, 1'b0, 1'b0, 4'h7, "R7");
    step(1'b0, 1'b0, 1'b0, 4'h7, "R8");
    step(1'b0, 1'b0, 1'b0, 4'hF, "R9");
    step(1'b0, 1'b0, 1'b0, 4'h0, "R9");
    step(1'b0, 1'b0, 1'b1, 4'h9, "R9/R4");

    // R3/R2: run past step 15 with no clear
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b0, 4'hC, "R2/R3");
    step(1'b0, 1'b0, 1'b1, 4'hC, "R4");

    // R5: halt during decode blocks latching
    step(1'b0, 1'b0, 1'b0, 4'h0, "R6");
    step(1'b0, 1'b0, 1'b0, 4'h0, "R7");
    step(1'b0, 1'b1, 1'b0, 4'h0, "R5");
    step(1'b0, 1'b1, 1'b0, 4'h6, "R5");
    step(1'b0, 1'b0, 1'b0, 4'h0, "R8");
    step(1'b0, 1'b0, 1'b0, 4'h3, "R10");

    // R1: reset in mid-instruction
    step(1'b1, 1'b0, 1'b0, 4'h3, "R1");
    step(1'b0, 1'b0, 1'b0, 4'h3, "R1/R6");
    step(1'b0, 1'b0, 1'b0, 4'h3, "R7");
    step(1'b0, 1'b0, 1'b0, 4'hE, "R8");
    step(1'b0, 1'b0, 1'b0, 4'hE, "R10");
    step(1'b0, 1'b0, 1'b1, 4'hE, "R11/R4");
    step(1'b0, 1'b0, 1'b0, 4'hE, "R4/R6");

    repeat (3) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule